// File: doc/BRIEF.md
# Two-Stage Refreshable Watchdog Timer

This block watches a free-running 64-bit system tick counter and expects software to refresh it on a regular basis. Once switched on, it arms a 64-bit compare value at the current tick count plus a programmed period. When the counter reaches or passes that value, the block raises a warning interrupt and re-arms for one more period. If software still has not refreshed when the second period ends, the block issues a one-cycle reset request and records that event in a status bit. This status bit survives the system reset, so software can tell after boot that the watchdog caused the reset.

Software reaches the block through a 32-bit register port with two chip selects. The control frame holds a control/status word, a period register and the compare value. The refresh frame accepts any write as a refresh. A parameter selects a 32-bit period or a 48-bit period.

Two active-low resets are used, and both are assumed to be released synchronously to `clk` by the surrounding reset logic. `rst_n` clears all state except the reset-cause bit. `por_n` clears the reset-cause bit as well.

Top module: `wdog_two_stage`

## Requirements
- R1: Writing 1 to bit 0 (enable) of control word 0 while disabled loads the compare value with counter + period. With the counter advancing one per cycle, `irq_warn` rises exactly period cycles after the enabling write edge.
- R2: With no refresh, `rst_req` pulses high for exactly one cycle, period cycles after the warning rises (2 × period after enabling). It only pulses while `irq_warn` is high.
- R3: Bit 2 of control word 0 is the reset-cause flag. It is set with the `rst_req` pulse and is cleared only by `por_n` or by writing 1 to that bit. It stays set through `rst_n`.
- R4: Any write to the refresh frame while enabled, whatever the data or word, clears `irq_warn` on the next cycle and re-arms the compare value to counter + period.
- R5: A write to the period words (word 2 low, word 3 high) while enabled is a refresh that uses the newly written period.
- R6: With VERSION=1 the period is 48 bits. Bits 31:16 of word 3 read as zero and ignore writes. With VERSION=0, word 3 reads zero.
- R7: A refresh write that lands on the same cycle as the first-stage expiry wins: `irq_warn` stays low and the stage restarts from that cycle.
- R8: Writing 0 to the enable bit drops `irq_warn` on the next cycle. While disabled, neither output asserts and the compare value does not advance.
- R9: The compare value is readable and writable as words 4 (low) and 5 (high). A stage expires when counter ≥ compare value.
- R10: `irq_warn` is level-sensitive and equals bit 1 of control word 0.
- R11: Reads of the refresh frame return zero. `req_ready` is always high.
- R12: After reset, control word 0, the period and both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| por_n | input | 1 | Power-on reset, active low; also clears the reset-cause flag |
| sys_cnt | input | 64 | Free-running system tick counter |
| req_valid | input | 1 | Register access valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel_ctrl | input | 1 | Selects the control frame |
| req_sel_rfsh | input | 1 | Selects the refresh frame |
| req_word | input | 3 | 32-bit word index within the frame |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted (always 1) |
| rsp_rdata | output | 32 | Read data, same cycle as the request |
| irq_warn | output | 1 | First-stage warning interrupt, level |
| rst_req | output | 1 | Second-stage reset request, one-cycle pulse |

## Verification
The critical collision is a refresh write against the first-stage expiry in the same clock. The bench enables the timer, counts cycles from the enabling edge and places a refresh-frame write on exactly the edge where the counter equals the compare value. It then requires the warning to stay low on the following cycle. It also requires the next warning to arrive a full period after that edge, and not immediately afterwards. A second collision sets a disable write against a pending expiry. There the disable must win, with no reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 64;
  localparam int DAT_W = 32;
  localparam int WRD_W = 3;

  // control frame word indices
  localparam logic [WRD_W-1:0] WD_CSR    = 3'd0;
  localparam logic [WRD_W-1:0] WD_PER_LO = 3'd2;
  localparam logic [WRD_W-1:0] WD_PER_HI = 3'd3;
  localparam logic [WRD_W-1:0] WD_CMP_LO = 3'd4;
  localparam logic [WRD_W-1:0] WD_CMP_HI = 3'd5;

  // control/status bit positions
  localparam int CSR_EN   = 0;
  localparam int CSR_WARN = 1;
  localparam int CSR_BITE = 2;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int VERSION = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_sel_ctrl,
  input  logic             req_sel_rfsh,
  input  logic [WRD_W-1:0] req_word,
  input  logic [DAT_W-1:0] req_wdata,
  input  logic             warn_q,
  input  logic             bite_sts_q,
  input  logic [CNT_W-1:0] cmp_q,
  output logic [DAT_W-1:0] rdata,
  output logic             en_q,
  output logic [CNT_W-1:0] per_nx,
  output logic             start_p,
  output logic             stop_p,
  output logic             refresh_p,
  output logic             bite_clr,
  output logic             cmp_wr_lo,
  output logic             cmp_wr_hi
);
  localparam int PER_W = (VERSION == 0) ? 32 : 48;
  localparam logic [CNT_W-1:0] PER_MASK = {CNT_W{1'b1}} >> (CNT_W - PER_W);

  logic             wr_ctrl;
  logic             en_d;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] per_d;

  assign wr_ctrl = req_valid & req_write & req_sel_ctrl;

  // next-state decode
  always_comb begin
    en_d      = en_q;
    per_d     = per_q;
    start_p   = 1'b0;
    stop_p    = 1'b0;
    refresh_p = 1'b0;
    bite_clr  = 1'b0;
    cmp_wr_lo = 1'b0;
    cmp_wr_hi = 1'b0;
    if (req_valid && req_write && req_sel_rfsh) refresh_p = en_q;
    if (wr_ctrl) begin
      case (req_word)
        WD_CSR: begin
          en_d     = req_wdata[CSR_EN];
          start_p  = req_wdata[CSR_EN] & ~en_q;
          stop_p   = ~req_wdata[CSR_EN] & en_q;
          bite_clr = req_wdata[CSR_BITE];
        end
        WD_PER_LO: begin
          per_d[DAT_W-1:0] = req_wdata;
          refresh_p        = en_q;
        end
        WD_PER_HI: begin
          per_d[CNT_W-1:DAT_W] = req_wdata;
          refresh_p            = en_q;
        end
        WD_CMP_LO: cmp_wr_lo = 1'b1;
        WD_CMP_HI: cmp_wr_hi = 1'b1;
        default: ;
      endcase
    end
    per_d = per_d & PER_MASK;
  end

  assign per_nx = per_d;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      per_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= en_d;
      per_q <= per_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (req_sel_ctrl) begin
      case (req_word)
        WD_CSR: begin
          rdata[CSR_EN]   = en_q;
          rdata[CSR_WARN] = warn_q;
          rdata[CSR_BITE] = bite_sts_q;
        end
        WD_PER_LO: rdata = per_q[DAT_W-1:0];
        WD_PER_HI: rdata = per_q[CNT_W-1:DAT_W];
        WD_CMP_LO: rdata = cmp_q[DAT_W-1:0];
        WD_CMP_HI: rdata = cmp_q[CNT_W-1:DAT_W];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic [CNT_W-1:0] sys_cnt,
  input  logic             en_q,
  input  logic [CNT_W-1:0] per_nx,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             refresh_p,
  input  logic             bite_clr,
  input  logic             cmp_wr_lo,
  input  logic             cmp_wr_hi,
  input  logic [DAT_W-1:0] wdata,
  output logic [CNT_W-1:0] cmp_q,
  output logic             warn_q,
  output logic             bite_q,
  output logic             bite_sts_q
);
  logic [CNT_W-1:0] cmp_d;
  logic             warn_d;
  logic             bite_d;
  logic             sts_d;
  logic             expire;

  assign expire = en_q && (sys_cnt >= cmp_q);

  // stage sequencing: stop > refresh/start > direct compare write > expiry
  always_comb begin
    cmp_d  = cmp_q;
    warn_d = warn_q;
    bite_d = 1'b0;
    sts_d  = bite_sts_q & ~bite_clr;
    if (stop_p) begin
      warn_d = 1'b0;
    end else if (start_p || refresh_p) begin
      cmp_d  = sys_cnt + per_nx;
      warn_d = 1'b0;
    end else if (cmp_wr_lo || cmp_wr_hi) begin
      if (cmp_wr_lo) cmp_d[DAT_W-1:0]     = wdata;
      if (cmp_wr_hi) cmp_d[CNT_W-1:DAT_W] = wdata;
    end else if (!en_q) begin
      warn_d = 1'b0;
    end else if (expire) begin
      cmp_d = sys_cnt + per_nx;
      if (!warn_q) begin
        warn_d = 1'b1;
      end else begin
        bite_d = 1'b1;
        sts_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      warn_q <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      warn_q <= warn_d;
      bite_q <= bite_d;
    end
  end

  // reset-cause flag lives on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) bite_sts_q <= 1'b0;
    else        bite_sts_q <= sts_d;
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int VERSION = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic [CNT_W-1:0] sys_cnt,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_sel_ctrl,
  input  logic             req_sel_rfsh,
  input  logic [WRD_W-1:0] req_word,
  input  logic [DAT_W-1:0] req_wdata,
  output logic             req_ready,
  output logic [DAT_W-1:0] rsp_rdata,
  output logic             irq_warn,
  output logic             rst_req
);
  logic             en_q;
  logic [CNT_W-1:0] per_nx;
  logic             start_p;
  logic             stop_p;
  logic             refresh_p;
  logic             bite_clr;
  logic             cmp_wr_lo;
  logic             cmp_wr_hi;
  logic [CNT_W-1:0] cmp_q;
  logic             warn_q;
  logic             bite_q;
  logic             bite_sts_q;

  wdog_regs #(.VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_sel_ctrl(req_sel_ctrl), .req_sel_rfsh(req_sel_rfsh),
    .req_word(req_word), .req_wdata(req_wdata),
    .warn_q(warn_q), .bite_sts_q(bite_sts_q), .cmp_q(cmp_q),
    .rdata(rsp_rdata), .en_q(en_q), .per_nx(per_nx),
    .start_p(start_p), .stop_p(stop_p), .refresh_p(refresh_p),
    .bite_clr(bite_clr), .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi)
  );

  wdog_stage u_stage (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sys_cnt(sys_cnt),
    .en_q(en_q), .per_nx(per_nx), .start_p(start_p), .stop_p(stop_p),
    .refresh_p(refresh_p), .bite_clr(bite_clr),
    .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi), .wdata(req_wdata),
    .cmp_q(cmp_q), .warn_q(warn_q), .bite_q(bite_q), .bite_sts_q(bite_sts_q)
  );

  assign req_ready = 1'b1;
  assign irq_warn  = warn_q;
  assign rst_req   = bite_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk,
  input logic rst_n,
  input logic por_n,
  input logic en,
  input logic refresh,
  input logic sts_clr,
  input logic sts,
  input logic irq,
  input logic rst_req
);
  // R2
  bite_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R2
  bite_after_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq);
  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
  // R4
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !irq);
  // R3
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sts && !sts_clr) |=> sts);
  // R1
  warn_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en));
endmodule

bind wdog_two_stage wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .en(en_q),
  .refresh(refresh_p), .sts_clr(bite_clr), .sts(bite_sts_q),
  .irq(irq_warn), .rst_req(rst_req)
);

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CSR = 3'd0, A_PLO = 3'd2, A_PHI = 3'd3, A_CLO = 3'd4;
  // period, expected warn edge, expected reset-request edge
  localparam int VEC [4][3] = '{'{3, 3, 6}, '{5, 5, 10}, '{8, 8, 16}, '{13, 13, 26}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic [63:0] cnt = 64'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sel_ctrl = 1'b0, req_sel_rfsh = 1'b0;
  logic [2:0]  req_word = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        irq_warn, rst_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  wdog_two_stage u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sys_cnt(cnt),
    .req_valid(req_valid), .req_write(req_write), .req_sel_ctrl(req_sel_ctrl),
    .req_sel_rfsh(req_sel_rfsh), .req_word(req_word), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .irq_warn(irq_warn), .rst_req(rst_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) cnt <= cnt + 64'd1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit rf, input logic [2:0] a, input logic [31:0] d, input bit rel = 1'b0);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_sel_ctrl = !rf; req_sel_rfsh = rf;
    req_word = a; req_wdata = rel ? (cnt[31:0] + d) : d;
    @(negedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_sel_ctrl = 1'b0; req_sel_rfsh = 1'b0;
  endtask

  task automatic rd(input bit rf, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_sel_ctrl = !rf; req_sel_rfsh = rf; req_word = a;
    #1 d = rsp_rdata;
    @(negedge clk); #1;
    req_valid = 1'b0; req_sel_ctrl = 1'b0; req_sel_rfsh = 1'b0;
  endtask

  // counts edges from the last write edge until the chosen output is high
  task automatic wait_sig(input bit bite, input int lim, output int k);
    k = 0;
    while (((bite ? rst_req : irq_warn) == 1'b0) && k < lim) begin
      @(negedge clk); #1;
      k++;
    end
  endtask

  task automatic setup(input int per);
    wr(0, A_CSR, 32'h4);
    wr(0, A_PLO, per);
    wr(0, A_PHI, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c1;
    int k, k2;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1; por_n = 1'b1;

    // R12 reset state
    rd(0, A_CSR, d); chk(d == 0, "R12 csr", d, 0);
    rd(0, A_PLO, d); chk(d == 0, "R12 period", d, 0);
    chk(!irq_warn && !rst_req && req_ready, "R12 outputs", {irq_warn, rst_req, req_ready}, 3'b001);

    // R6 upper period bits
    wr(0, A_PHI, 32'hFFFF_ABCD);
    rd(0, A_PHI, d); chk(d == 32'h0000_ABCD, "R6 period high", d, 32'h0000_ABCD);
    // R11 refresh frame reads zero
    rd(1, 3'd0, d); chk(d == 0, "R11 refresh read", d, 0);

    // table walk: R1 R2 R10 R3
    foreach (VEC[i]) begin
      setup(VEC[i][0]);
      wr(0, A_CSR, 32'h1);
      wait_sig(0, 200, k);
      chk(k == VEC[i][1], "R1 warn edge", k, VEC[i][1]);
      wait_sig(1, 200, k2);
      chk(k + k2 == VEC[i][2], "R2 reset edge", k + k2, VEC[i][2]);
      @(negedge clk); #1;
      chk(!rst_req, "R2 pulse width", rst_req, 0);
      rd(0, A_CSR, d);
      chk(d[2:0] == 3'b111 && irq_warn == d[1], "R10 csr mirrors", d, 7);
    end

    // R9 direct compare write
    setup(1000);
    wr(0, A_CSR, 32'h1);
    wr(0, A_CLO, 32'd3, 1'b1);
    wait_sig(0, 50, k); chk(k == 3, "R9 compare expiry", k, 3);
    // R4 refresh clears warning
    wr(1, 3'd7, 32'hDEAD_BEEF);
    chk(!irq_warn, "R4 warn cleared", irq_warn, 0);
    wait_sig(0, 2000, k); chk(k == 1000, "R4 restart", k, 1000);

    // R8 disable
    setup(4);
    wr(0, A_CSR, 32'h1);
    wait_sig(0, 50, k); chk(k == 4, "R8 armed", k, 4);
    wr(0, A_CSR, 32'h0);
    rd(0, A_CLO, c1);
    chk(!irq_warn, "R8 warn drop", irq_warn, 0);
    k2 = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); #1;
      if (irq_warn || rst_req) k2++;
    end
    chk(k2 == 0, "R8 quiet", k2, 0);
    rd(0, A_CLO, d); chk(d == c1, "R8 compare held", d, c1);

    // R5 period write is a refresh
    setup(6);
    wr(0, A_CSR, 32'h1);
    repeat (2) @(negedge clk);
    wr(0, A_PLO, 32'd6);
    wait_sig(0, 50, k); chk(k == 6, "R5 period refresh", k, 6);

    // R7 refresh on the expiry edge
    setup(6);
    wr(0, A_CSR, 32'h1);
    repeat (4) @(negedge clk);
    wr(1, 3'd0, 32'h0);
    chk(!irq_warn, "R7 refresh wins", irq_warn, 0);
    wait_sig(0, 50, k); chk(k == 6, "R7 restart", k, 6);

    // R3 reset-cause flag survives rst_n
    setup(2);
    wr(0, A_CSR, 32'h1);
    wait_sig(0, 50, k);
    wait_sig(1, 50, k);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    rd(0, A_CSR, d); chk(d == 32'h4, "R3 flag kept", d, 4);
    wr(0, A_CSR, 32'h4);
    rd(0, A_CSR, d); chk(d == 0, "R3 flag cleared", d, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule